// File: doc/BRIEF.md
# Masked Vector Register Move Unit

This unit executes one aligned move of packed integers on a 512-bit vector datapath. A front end hands it the decoded fields of a single move: which encoding family carried it, whether data flows into the register operand or out to the register/memory operand, the element-size bit, the reserved register-specifier field, the vector length, the masking controls, the source vector, the current contents of the destination, and the effective address when a memory operand is involved. One clock later the unit presents the new destination image, one write strobe per 32-bit lane, and two fault flags.

Per-element masking is applied only to the extended encoding, where a masked-off element is either kept (merge) or cleared (zero). Register writes from the two vector encodings clear everything above the vector length, while the oldest 128-bit form leaves the upper bits alone. Writes to memory never zero and never touch bytes outside the selected elements, so the strobes can drive a byte-enable directly. A misaligned memory address or a malformed reserved field suppresses the whole move.

Top module: `vec_masked_move`

## Requirements
- R1: `enc_kind` codes are 0 = legacy, 1 = VEX, 2 = EVEX, 3 = reserved. Only under EVEX does `w_bit` = 1 select 64-bit elements (element j covers lanes 2j and 2j+1 and uses `mask[j]`); every other case uses 32-bit elements where element j is lane j.
- R2: `vlen` codes 0, 1, 2 mean 128, 256, 512 bits; a legacy move always works on 128 bits whatever `vlen` holds.
- R3: An element inside the vector length that is selected (mask bit set, masking off, or a non-EVEX encoding) takes the source value, and the `lane_wr` bits of its lanes are 1; all other `lane_wr` bits are 0.
- R4: For an EVEX register write (not a memory store) a masked-off element inside the length keeps the old value when `zero_mode` = 0 and becomes zero when `zero_mode` = 1.
- R5: A store is `dir_store` = 1 (register operand into register/memory operand) with `mem_op` = 1; it keeps every unselected element and every bit beyond the length at its old value, and `zero_mode` has no effect. With `mem_op` = 0 either direction is a register copy and follows R4 and R6.
- R6: For VEX and EVEX register writes, bits from the vector length up to bit 511 become zero; a legacy register write leaves bits 511:128 unchanged.
- R7: Legacy and VEX moves ignore `mask_en`, `mask` and `zero_mode` and always copy the whole length.
- R8: With `mem_op` = 1, `gp_fault` is raised when `mem_addr` is not a multiple of the length in bytes (16, 32 or 64; 64 for `vlen` = 3).
- R9: `ud_fault` is raised when the encoding is not legacy and `vvvv` is not 4'b1111, when `enc_kind` = 3, when a VEX move has `vlen` of 2 or 3, or when an EVEX move has `vlen` = 3.
- R10: When either fault flag is raised, `dst_data` equals `old_data` and `lane_wr` is all zero.
- R11: Results appear on the clock edge after `in_valid` with a one-cycle `out_valid` pulse; `out_valid` is low in every cycle not following `in_valid`, and reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One move is presented this cycle |
| enc_kind | input | 2 | Encoding family (R1) |
| dir_store | input | 1 | 0: into register operand, 1: out to register/memory operand |
| w_bit | input | 1 | Element-size bit |
| vvvv | input | 4 | Reserved register-specifier field |
| vlen | input | 2 | Vector length code |
| zero_mode | input | 1 | 1: masked-off elements are cleared |
| mask_en | input | 1 | 1: per-element mask applies |
| mask | input | 16 | Per-element mask |
| src_data | input | 512 | Source vector |
| old_data | input | 512 | Current destination contents |
| mem_addr | input | AW | Effective address of the memory operand |
| mem_op | input | 1 | 1: one operand is in memory |
| out_valid | output | 1 | Result valid pulse |
| dst_data | output | 512 | New destination image |
| lane_wr | output | 16 | Per-32-bit-lane write strobes |
| gp_fault | output | 1 | Misaligned memory operand |
| ud_fault | output | 1 | Malformed encoding |

## Verification
Since the whole result is formed in one combinational stage and registered once, any wrong lane decision shows up at the ports on the very next cycle after `in_valid`: a lane holding a source word without its strobe, a stale or zeroed word where the other was due, or a nonzero strobe during a fault. The sweep walks every combination of encoding, direction, operand kind, element width, length, masking and zeroing against three mask patterns, using lane words that encode the case number so a word from the wrong lane or wrong case cannot match by accident. Fault cases cover each wrong `vvvv` value and each misalignment step for each length.

// File: rtl/vmm_pkg.sv
package vmm_pkg;

  localparam int unsigned VEC_W  = 512;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned LANES  = VEC_W / LANE_W;
  localparam int unsigned BASE_LANES = 128 / LANE_W;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_VEX    = 2'd1,
    ENC_EVEX   = 2'd2,
    ENC_RSVD   = 2'd3
  } enc_e;

  // Lanes covered by the operation; legacy is pinned to 128 bits.
  function automatic int unsigned active_lanes(enc_e e, logic [1:0] vl);
    if (e == ENC_LEGACY) return BASE_LANES;
    case (vl)
      2'd0:    return BASE_LANES;
      2'd1:    return 2 * BASE_LANES;
      default: return LANES;
    endcase
  endfunction

  // Byte alignment demanded of a memory operand.
  function automatic int unsigned align_bytes(enc_e e, logic [1:0] vl);
    return active_lanes(e, vl) * (LANE_W / 8);
  endfunction

endpackage

// File: rtl/vmm_fault_check.sv
module vmm_fault_check
  import vmm_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  enc_e          enc,
  input  logic [3:0]    vvvv,
  input  logic [1:0]    vlen,
  input  logic          mem_op,
  input  logic [AW-1:0] mem_addr,
  output logic          gp,
  output logic          ud
);
  logic [AW-1:0] low_mask;
  logic          bad_spec, bad_len;

  always_comb begin
    low_mask = AW'(align_bytes(enc, vlen) - 1);
    gp       = mem_op && (|(mem_addr & low_mask));
    bad_spec = (enc != ENC_LEGACY) && (vvvv != 4'hF);
    bad_len  = ((enc == ENC_VEX) && vlen[1]) || ((enc == ENC_EVEX) && (vlen == 2'd3));
    ud       = (enc == ENC_RSVD) || bad_spec || bad_len;
  end
endmodule

// File: rtl/vmm_lane_ctrl.sv
module vmm_lane_ctrl
  import vmm_pkg::*;
(
  input  enc_e             enc,
  input  logic             w_bit,
  input  logic [1:0]       vlen,
  input  logic             mask_en,
  input  logic [LANES-1:0] mask,
  input  logic             zero_mode,
  input  logic             is_store,
  output logic [LANES-1:0] lane_sel,
  output logic [LANES-1:0] lane_zero
);
  logic        wide, use_mask, zero_in, zero_out;
  int unsigned n_act;

  always_comb begin
    n_act    = active_lanes(enc, vlen);
    wide     = (enc == ENC_EVEX) && w_bit;
    use_mask = (enc == ENC_EVEX) && mask_en;
    zero_in  = (enc == ENC_EVEX) && zero_mode && !is_store;
    zero_out = (enc != ENC_LEGACY) && !is_store;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic in_rng, mbit;
    always_comb begin
      in_rng       = (l < n_act);
      mbit         = wide ? mask[l/2] : mask[l];
      lane_sel[l]  = in_rng && (!use_mask || mbit);
      lane_zero[l] = !lane_sel[l] && (in_rng ? zero_in : zero_out);
    end
  end
endmodule

// File: rtl/vmm_lane_mux.sv
module vmm_lane_mux
  import vmm_pkg::*;
(
  input  logic             fault,
  input  logic [LANES-1:0] lane_sel,
  input  logic [LANES-1:0] lane_zero,
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] old,
  output logic [VEC_W-1:0] res,
  output logic [LANES-1:0] strobe
);
  for (genvar l = 0; l < LANES; l++) begin : g_mux
    always_comb begin
      if (fault)             res[l*LANE_W +: LANE_W] = old[l*LANE_W +: LANE_W];
      else if (lane_sel[l])  res[l*LANE_W +: LANE_W] = src[l*LANE_W +: LANE_W];
      else if (lane_zero[l]) res[l*LANE_W +: LANE_W] = '0;
      else                   res[l*LANE_W +: LANE_W] = old[l*LANE_W +: LANE_W];
      strobe[l] = lane_sel[l] && !fault;
    end
  end
endmodule

// File: rtl/vec_masked_move.sv
module vec_masked_move
  import vmm_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       enc_kind,
  input  logic             dir_store,
  input  logic             w_bit,
  input  logic [3:0]       vvvv,
  input  logic [1:0]       vlen,
  input  logic             zero_mode,
  input  logic             mask_en,
  input  logic [LANES-1:0] mask,
  input  logic [VEC_W-1:0] src_data,
  input  logic [VEC_W-1:0] old_data,
  input  logic [AW-1:0]    mem_addr,
  input  logic             mem_op,
  output logic             out_valid,
  output logic [VEC_W-1:0] dst_data,
  output logic [LANES-1:0] lane_wr,
  output logic             gp_fault,
  output logic             ud_fault
);
  enc_e             enc;
  logic             is_store, gp_n, ud_n, fault_n;
  logic [LANES-1:0] lane_sel, lane_zero, strobe_n;
  logic [VEC_W-1:0] res_n;

  assign enc      = enc_e'(enc_kind);
  assign is_store = dir_store && mem_op;
  assign fault_n  = gp_n || ud_n;

  vmm_fault_check #(.AW(AW)) u_fault (
    .enc(enc), .vvvv(vvvv), .vlen(vlen), .mem_op(mem_op),
    .mem_addr(mem_addr), .gp(gp_n), .ud(ud_n)
  );

  vmm_lane_ctrl u_ctrl (
    .enc(enc), .w_bit(w_bit), .vlen(vlen), .mask_en(mask_en), .mask(mask),
    .zero_mode(zero_mode), .is_store(is_store),
    .lane_sel(lane_sel), .lane_zero(lane_zero)
  );

  vmm_lane_mux u_mux (
    .fault(fault_n), .lane_sel(lane_sel), .lane_zero(lane_zero),
    .src(src_data), .old(old_data), .res(res_n), .strobe(strobe_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_data  <= '0;
      lane_wr   <= '0;
      gp_fault  <= 1'b0;
      ud_fault  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_data <= res_n;
        lane_wr  <= strobe_n;
        gp_fault <= gp_n;
        ud_fault <= ud_n;
      end
    end
  end
endmodule

// File: rtl/vec_masked_move_chk.sv
module vec_masked_move_chk
  import vmm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       enc_kind,
  input logic             dir_store,
  input logic             mem_op,
  input logic [VEC_W-1:0] src_data,
  input logic [VEC_W-1:0] old_data,
  input logic             out_valid,
  input logic [VEC_W-1:0] dst_data,
  input logic [LANES-1:0] lane_wr,
  input logic             gp_fault,
  input logic             ud_fault
);
  function automatic logic [VEC_W-1:0] lane_bits(logic [LANES-1:0] s);
    logic [VEC_W-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*LANE_W +: LANE_W] = {LANE_W{s[l]}};
    return r;
  endfunction

  a_r3_strobed_from_src: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((dst_data ^ $past(src_data)) & lane_bits(lane_wr)) == '0));

  a_r5_store_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(dir_store && mem_op)) |->
      (((dst_data ^ $past(old_data)) & ~lane_bits(lane_wr)) == '0));

  a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (gp_fault || ud_fault)) |-> (lane_wr == '0 && dst_data == $past(old_data)));

  a_r2_legacy_low_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(enc_kind) == 2'd0) |-> (lane_wr[LANES-1:BASE_LANES] == '0));

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

bind vec_masked_move vec_masked_move_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_kind(enc_kind),
  .dir_store(dir_store), .mem_op(mem_op), .src_data(src_data),
  .old_data(old_data), .out_valid(out_valid), .dst_data(dst_data),
  .lane_wr(lane_wr), .gp_fault(gp_fault), .ud_fault(ud_fault)
);

// File: tb/vec_masked_move_test.sv
`timescale 1ns/1ps
module vec_masked_move_test;
  localparam int AW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] enc_kind = '0;
  logic dir_store = 1'b0, w_bit = 1'b0, zero_mode = 1'b0, mask_en = 1'b0, mem_op = 1'b0;
  logic [3:0] vvvv = 4'hF;
  logic [1:0] vlen = '0;
  logic [15:0] mask = '0;
  logic [511:0] src_data = '0, old_data = '0;
  logic [AW-1:0] mem_addr = '0;
  logic out_valid, gp_fault, ud_fault;
  logic [511:0] dst_data;
  logic [15:0] lane_wr;

  int checks = 0;
  int errors = 0;
  int case_no = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vec_masked_move #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_kind(enc_kind),
    .dir_store(dir_store), .w_bit(w_bit), .vvvv(vvvv), .vlen(vlen),
    .zero_mode(zero_mode), .mask_en(mask_en), .mask(mask),
    .src_data(src_data), .old_data(old_data), .mem_addr(mem_addr),
    .mem_op(mem_op), .out_valid(out_valid), .dst_data(dst_data),
    .lane_wr(lane_wr), .gp_fault(gp_fault), .ud_fault(ud_fault)
  );

  task automatic check512(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s case %0d: actual %h expected %h", tag, case_no, act, exp);
    end
  endtask

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s case %0d: actual %h expected %h", tag, case_no, act, exp);
    end
  endtask

  // Independent model, walked element by element.
  task automatic model(input int e, input bit d, input bit m, input bit w, input int vl,
                       input logic [3:0] vv, input bit z, input bit me, input logic [15:0] k,
                       input logic [AW-1:0] a, input logic [511:0] s, input logic [511:0] o,
                       output logic [511:0] xd, output logic [15:0] xs,
                       output bit xg, output bit xu);
    int vb, eb, per;
    bit st, inr, take, clr;
    if (e == 0) vb = 128;
    else vb = (vl == 0) ? 128 : (vl == 1) ? 256 : 512;
    xu = (e == 3) || (e != 0 && vv != 4'hF) || (e == 1 && vl >= 2) || (e == 2 && vl == 3);
    xg = m && ((a % AW'(vb / 8)) != 0);
    st = d && m;
    eb = (e == 2 && w) ? 64 : 32;
    per = eb / 32;
    xd = o;
    xs = '0;
    if (!(xu || xg)) begin
      for (int j = 0; j < 512 / eb; j++) begin
        inr  = (j * eb) < vb;
        take = inr && (e != 2 || !me || k[j]);
        clr  = inr ? (e == 2 && z && !st) : (!st && e != 0);
        if (take) begin
          for (int b = 0; b < eb; b++) xd[j*eb + b] = s[j*eb + b];
          for (int q = 0; q < per; q++) xs[j*per + q] = 1'b1;
        end else if (clr) begin
          for (int b = 0; b < eb; b++) xd[j*eb + b] = 1'b0;
        end
      end
    end
  endtask

  task automatic run_case(input int e, input bit d, input bit m, input bit w, input int vl,
                          input logic [3:0] vv, input bit z, input bit me,
                          input logic [15:0] k, input logic [AW-1:0] a);
    logic [511:0] s, o, xd;
    logic [15:0] xs;
    bit xg, xu;
    string dtag, stag;
    for (int l = 0; l < 16; l++) begin
      s[l*32 +: 32] = 32'hA000_0000 | (32'(case_no) << 8) | 32'(l + 1);
      o[l*32 +: 32] = 32'h5000_0000 | (32'(case_no) << 8) | 32'(l + 1);
    end
    model(e, d, m, w, vl, vv, z, me, k, a, s, o, xd, xs, xg, xu);
    enc_kind = 2'(e); dir_store = d; mem_op = m; w_bit = w; vlen = 2'(vl);
    vvvv = vv; zero_mode = z; mask_en = me; mask = k; mem_addr = a;
    src_data = s; old_data = o; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (xg || xu) dtag = "R10";
    else if (d && m) dtag = "R5";
    else if (e == 0) dtag = "R6";
    else if (e == 1) dtag = "R7";
    else if (me && k != 16'hFFFF) dtag = "R4";
    else dtag = "R6";
    if (e == 0) stag = "R2";
    else if (e == 2 && w) stag = "R1";
    else stag = "R3";
    check16("R11 out_valid", 16'(out_valid), 16'd1);
    check512(dtag, dst_data, xd);
    check16(stag, lane_wr, xs);
    check16("R8 gp_fault", 16'(gp_fault), 16'(xg));
    check16("R9 ud_fault", 16'(ud_fault), 16'(xu));
    case_no++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] pats [3];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h9A6C;
    repeat (3) @(negedge clk);
    // R11: reset state
    check16("R11 reset valid", 16'(out_valid), 16'd0);
    check512("R11 reset data", dst_data, '0);
    check16("R11 reset strobe", lane_wr, '0);
    check16("R11 reset faults", {14'd0, gp_fault, ud_fault}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Main sweep: R1..R7 and R11
    for (int e = 0; e < 3; e++)
      for (int d = 0; d < 2; d++)
        for (int m = 0; m < 2; m++)
          for (int w = 0; w < 2; w++)
            for (int vl = 0; vl < 3; vl++)
              for (int z = 0; z < 2; z++)
                for (int me = 0; me < 2; me++)
                  for (int p = 0; p < 3; p++)
                    run_case(e, d[0], m[0], w[0], vl, 4'hF, z[0], me[0], pats[p], 48'h0000_1234_5640);

    // R11: no pulse without a request
    @(negedge clk);
    check16("R11 idle valid", 16'(out_valid), 16'd0);

    // R9: every wrong reserved field, VEX and EVEX
    for (int e = 1; e < 3; e++)
      for (int vv = 0; vv < 15; vv++)
        run_case(e, 1'b0, 1'b0, 1'b0, 1, 4'(vv), 1'b0, 1'b1, 16'h00F3, 48'h0);
    // R9: reserved encoding and illegal lengths
    run_case(3, 1'b0, 1'b0, 1'b0, 0, 4'hF, 1'b0, 1'b0, 16'h0, 48'h0);
    run_case(1, 1'b0, 1'b0, 1'b0, 2, 4'hF, 1'b0, 1'b0, 16'h0, 48'h0);
    run_case(1, 1'b1, 1'b0, 1'b0, 3, 4'hF, 1'b0, 1'b0, 16'h0, 48'h0);
    run_case(2, 1'b0, 1'b0, 1'b1, 3, 4'hF, 1'b0, 1'b1, 16'h5, 48'h0);
    // R2/R9: legacy ignores a bad vvvv and any vlen
    run_case(0, 1'b0, 1'b0, 1'b0, 3, 4'h0, 1'b1, 1'b1, 16'h0, 48'h0);

    // R8: misalignment steps per length, loads and stores
    for (int e = 0; e < 3; e++)
      for (int vl = 0; vl < 3; vl++)
        for (int sh = 0; sh < 6; sh++)
          for (int d = 0; d < 2; d++)
            run_case(e, d[0], 1'b1, 1'b0, vl, 4'hF, 1'b0, 1'b0, 16'hFFFF,
                     48'h0000_0000_4000 | AW'(1 << sh));
    // R8: address ignored without a memory operand
    run_case(2, 1'b1, 1'b0, 1'b1, 2, 4'hF, 1'b1, 1'b1, 16'h3C, 48'h0000_0000_4001);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule